// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Read Controller

This block runs the host side of a two-channel converter that samples both inputs at the same instant and returns its results over a serial link. A one-cycle request on `start_i` makes the controller pulse an active-low convert strobe. It then waits for the converter's busy flag to go high and come back low. After that it opens a read frame: chip select goes low and a divided serial clock runs while the result bits are captured.

Two read modes are offered. The mode is sampled when the request is accepted. In dual-lane mode both data lines are shifted in parallel over a 12-edge frame. In single-lane mode only data line A is used. The frame then runs for 26 falling edges: the first channel's word comes first, then two zero fill bits that are thrown away, then the second channel's word.

When the frame closes, both words appear on the parallel outputs with a one-cycle valid pulse. If busy never rises, or never falls, within a set number of cycles, the controller drops the attempt, flags an error and returns to idle.

Top module: `dsadc_rd_ctrl`

## Requirements
- R1: `start_i` high at a clock edge while the controller is idle drives `cnv_n_o` low for exactly CNV_W cycles, starting the next cycle. `start_i` seen at any other time is ignored.
- R2: `cs_n_o` goes low only at the edge where `busy_i` is sampled low, and only after `busy_i` has been sampled high in the same attempt.
- R3: `sclk_o` is high whenever `cs_n_o` is high. After `cs_n_o` falls, `sclk_o` stays high for HALF_DIV cycles before its first falling edge.
- R4: Within a frame, `sclk_o` toggles every HALF_DIV cycles. The frame holds 12 falling edges in dual mode (`single_pin_i`=0) and 26 in single mode (`single_pin_i`=1). The mode is taken at the accepted start, and later changes to `single_pin_i` have no effect on that attempt.
- R5: In dual mode, the values present on `sdo_a_i` and `sdo_b_i` just before falling edge k (k=1..12) become bit 12-k of `res_a_o` and `res_b_o` respectively (MSB first).
- R6: In single mode, `sdo_a_i` before falling edges 1..12 forms `res_a_o` (MSB first). Edges 13 and 14 are discarded. Edges 15..26 form `res_b_o`. `sdo_b_i` is ignored.
- R7: HALF_DIV cycles after the last falling edge, `sclk_o` and `cs_n_o` rise together and `res_valid_o` pulses for that one cycle. The result outputs change only at that edge.
- R8: If `busy_i` is not seen high within TMO_CYC cycles of the strobe ending, or not seen low within TMO_CYC cycles after it was seen high, `err_o` pulses for one cycle, `cs_n_o` stays high and the controller returns to idle.
- R9: Under reset, `cnv_n_o`, `cs_n_o` and `sclk_o` are high, `res_valid_o` and `err_o` are low, and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken only while idle |
| single_pin_i | input | 1 | 1 = read both words over data line A, 0 = read both lines in parallel |
| busy_i | input | 1 | Converter busy flag |
| sdo_a_i | input | 1 | Serial data line A |
| sdo_b_i | input | 1 | Serial data line B |
| cnv_n_o | output | 1 | Active-low convert strobe |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| res_a_o | output | DATA_W | First channel result |
| res_b_o | output | DATA_W | Second channel result |
| res_valid_o | output | 1 | One-cycle pulse when results update |
| err_o | output | 1 | One-cycle pulse on busy timeout |

## Verification
The bench targets the following corner cases:
- **Fill bits in single mode.** Words of all zeros and all ones sit beside the two zero fill bits. A controller that kept the fill bits would return a second word shifted by two places.
- **Mode change mid-attempt.** The mode input is flipped, and a fresh start request is made, while busy is high. A design that sampled the mode late would run a frame of the wrong length. A design that accepted the extra start would pulse the strobe again.
- **Stale data on the unused line.** In single mode, line B carries inverted data. Picking up that line corrupts the second word.
- **Two distinct timeouts.** Busy never rising and busy never falling are each exercised. A broken timer either hangs or opens chip select with no result ready.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_FRAME
    } rd_state_e;

    typedef enum logic {
        RD_DUAL   = 1'b0,
        RD_SINGLE = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        DST_LANE_A,
        DST_LANE_B,
        DST_DROP
    } bit_dst_e;

    // Per-frame event strobes handed from the frame logic to the result stage
    typedef struct packed {
        logic shift_a;
        logic shift_b;
        logic close;
    } frame_ev_t;

    // Number of serial clock falling edges in one frame
    function automatic int unsigned frame_falls(rd_mode_e m, int unsigned dw, int unsigned pw);
        return (m == RD_SINGLE) ? (2 * dw + pw) : dw;
    endfunction

    // Where the bit sampled before falling edge idx+1 goes
    function automatic bit_dst_e route_bit(rd_mode_e m, int unsigned idx,
                                           int unsigned dw, int unsigned pw);
        if (m == RD_DUAL)       return DST_LANE_A;
        if (idx < dw)           return DST_LANE_A;
        if (idx < dw + pw)      return DST_DROP;
        return DST_LANE_B;
    endfunction

endpackage

// File: rtl/dsadc_sclk_div.sv
module dsadc_sclk_div #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] phase;
    logic          edge_now;

    assign edge_now = en_i && (phase == LAST);
    assign fall_o   = edge_now && sclk_o;
    assign rise_o   = edge_now && !sclk_o;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            phase  <= '0;
            sclk_o <= 1'b1;
        end else if (edge_now) begin
            phase  <= '0;
            sclk_o <= !sclk_o;
        end else begin
            phase  <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_wait_timer.sv
module dsadc_wait_timer #(
    parameter int unsigned LIMIT = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clr_i,
    output logic expire_o
);
    localparam int unsigned TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    assign expire_o = run_i && !clr_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || clr_i) cnt <= '0;
        else if (cnt != LAST)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dsadc_lane_shift.sv
module dsadc_lane_shift #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst)          word_o <= '0;
        else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/dsadc_rd_ctrl.sv
module dsadc_rd_ctrl
    import dsadc_pkg::*;
#(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned PAD_W    = 2,
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned CNV_W    = 3,
    parameter int unsigned TMO_CYC  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              single_pin_i,
    input  logic              busy_i,
    input  logic              sdo_a_i,
    input  logic              sdo_b_i,
    output logic              cnv_n_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] res_a_o,
    output logic [DATA_W-1:0] res_b_o,
    output logic              res_valid_o,
    output logic              err_o
);
    localparam int unsigned MAX_FALLS = 2 * DATA_W + PAD_W;
    localparam int unsigned FW        = $clog2(MAX_FALLS + 1);
    localparam int unsigned CCW       = (CNV_W > 1) ? $clog2(CNV_W) : 1;
    localparam logic [CCW-1:0] CNV_LAST = CCW'(CNV_W - 1);
    localparam int unsigned NLANE     = 2;

    rd_state_e          st;
    rd_mode_e           mode;
    logic [CCW-1:0]     ccnt;
    logic [FW-1:0]      nfall;
    logic [FW-1:0]      frame_len;
    logic               sck_fall, sck_rise, sck_en;
    logic               tmr_run, tmr_clr, tmr_exp;
    bit_dst_e           dst;
    frame_ev_t          ev;
    logic [NLANE-1:0]   lane_shift;
    logic [NLANE-1:0]   lane_bit;
    logic [DATA_W-1:0]  lane_word [NLANE];

    // ---------------- serial clock ----------------
    assign sck_en = (st == ST_FRAME);

    dsadc_sclk_div #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sck_en),
        .sclk_o (sclk_o),
        .fall_o (sck_fall),
        .rise_o (sck_rise)
    );

    // ---------------- busy watchdog ----------------
    assign tmr_run = (st == ST_WAIT_HI) || (st == ST_WAIT_LO);
    assign tmr_clr = (st == ST_WAIT_HI) && busy_i;

    dsadc_wait_timer #(.LIMIT(TMO_CYC)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .run_i    (tmr_run),
        .clr_i    (tmr_clr),
        .expire_o (tmr_exp)
    );

    // ---------------- bit routing ----------------
    assign frame_len = FW'(frame_falls(mode, DATA_W, PAD_W));
    assign dst       = route_bit(mode, 32'(nfall), DATA_W, PAD_W);

    always_comb begin
        ev         = '0;
        ev.shift_a = sck_en && sck_fall && (dst == DST_LANE_A);
        ev.shift_b = sck_en && sck_fall &&
                     ((mode == RD_DUAL) || (dst == DST_LANE_B));
        ev.close   = sck_en && sck_rise && (nfall == frame_len);
    end

    assign lane_shift = {ev.shift_b, ev.shift_a};
    assign lane_bit   = {(mode == RD_SINGLE) ? sdo_a_i : sdo_b_i, sdo_a_i};

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            dsadc_lane_shift #(.W(DATA_W)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .shift_i (lane_shift[g]),
                .bit_i   (lane_bit[g]),
                .word_o  (lane_word[g])
            );
        end
    endgenerate

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            mode        <= RD_DUAL;
            ccnt        <= '0;
            nfall       <= '0;
            cnv_n_o     <= 1'b1;
            cs_n_o      <= 1'b1;
            res_a_o     <= '0;
            res_b_o     <= '0;
            res_valid_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            err_o       <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st      <= ST_CONV;
                        mode    <= rd_mode_e'(single_pin_i);
                        ccnt    <= '0;
                        cnv_n_o <= 1'b0;
                    end
                end
                ST_CONV: begin
                    ccnt <= ccnt + 1'b1;
                    if (ccnt == CNV_LAST) begin
                        cnv_n_o <= 1'b1;
                        st      <= ST_WAIT_HI;
                    end
                end
                ST_WAIT_HI: begin
                    if (busy_i) begin
                        st <= ST_WAIT_LO;
                    end else if (tmr_exp) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (!busy_i) begin
                        st     <= ST_FRAME;
                        cs_n_o <= 1'b0;
                        nfall  <= '0;
                    end else if (tmr_exp) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_FRAME: begin
                    if (sck_fall) nfall <= nfall + 1'b1;
                    if (ev.close) begin
                        cs_n_o      <= 1'b1;
                        res_valid_o <= 1'b1;
                        res_a_o     <= lane_word[0];
                        res_b_o     <= lane_word[1];
                        st          <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsadc_rd_ctrl_chk.sv
module dsadc_rd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_i,
    input logic cnv_n_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic res_valid_o,
    input logic err_o
);
    // R1: strobe only opens after a request
    a_r1_cnv_from_start: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_n_o) |-> $past(start_i));

    // R1: no strobe while a frame is open
    a_r1_no_cnv_in_frame: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> cnv_n_o);

    // R2: chip select opens only after busy was seen low
    a_r2_cs_after_busy_low: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !$past(busy_i));

    // R3: clock idles high outside a frame
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);

    // R3: clock does not fall together with chip select
    a_r3_no_coincident_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> sclk_o);

    // R4: clock falls only inside a frame
    a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> !cs_n_o);

    // R7: valid marks frame close with clock high
    a_r7_valid_closes_frame: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ($rose(cs_n_o) && sclk_o));

    // R7: valid is a single-cycle pulse
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    // R8: an error never accompanies an open frame or a result
    a_r8_err_alone: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (cs_n_o && !res_valid_o));
endmodule

bind dsadc_rd_ctrl dsadc_rd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_i      (busy_i),
    .cnv_n_o     (cnv_n_o),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .res_valid_o (res_valid_o),
    .err_o       (err_o)
);

// File: tb/dsadc_rd_ctrl_tb.sv
`timescale 1ns/1ps
module dsadc_rd_ctrl_tb;
    localparam int DW  = 12;
    localparam int PW  = 2;
    localparam int H   = 2;
    localparam int CNV = 3;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, single_pin_i = 1'b0, busy_i = 1'b0;
    logic sdo_a_i, sdo_b_i;
    logic cnv_n_o, cs_n_o, sclk_o, res_valid_o, err_o;
    logic [DW-1:0] res_a_o, res_b_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dsadc_rd_ctrl #(.DATA_W(DW), .PAD_W(PW), .HALF_DIV(H), .CNV_W(CNV), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .single_pin_i(single_pin_i),
        .busy_i(busy_i), .sdo_a_i(sdo_a_i), .sdo_b_i(sdo_b_i),
        .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .res_a_o(res_a_o), .res_b_o(res_b_o), .res_valid_o(res_valid_o), .err_o(err_o)
    );

    // ---------- converter serial model ----------
    logic [25:0] stream_a = '1, stream_b = '1;
    int bidx = 0;
    always @(negedge cs_n_o) bidx = 0;
    always @(negedge sclk_o) if (!cs_n_o) bidx++;
    assign sdo_a_i = (cs_n_o || bidx > 25) ? 1'b1 : stream_a[25 - bidx];
    assign sdo_b_i = (cs_n_o || bidx > 25) ? 1'b1 : stream_b[25 - bidx];

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------- behavioural reference ----------
    logic e_cnv_n = 1, e_cs_n = 1, e_sclk = 1, e_valid = 0, e_err = 0;
    logic [DW-1:0] e_res_a = '0, e_res_b = '0;
    logic [DW-1:0] cur_wa = '0, cur_wb = '0, m_wa, m_wb;
    logic m_single;
    string res_tag = "R5 result";
    bit got;

    initial begin
        forever begin
            @(posedge clk);
            e_valid = 0; e_err = 0;
            if (rst) begin
                e_cnv_n = 1; e_cs_n = 1; e_sclk = 1; e_res_a = '0; e_res_b = '0;
                continue;
            end
            if (start_i) begin
                m_single = single_pin_i; m_wa = cur_wa; m_wb = cur_wb;
                e_cnv_n = 0;
                repeat (CNV) @(posedge clk);
                e_cnv_n = 1;
                got = 0;
                for (int k = 0; k < TMO; k++) begin
                    @(posedge clk);
                    if (busy_i) begin got = 1; break; end
                end
                if (!got) begin e_err = 1; continue; end
                got = 0;
                for (int k = 0; k < TMO; k++) begin
                    @(posedge clk);
                    if (!busy_i) begin got = 1; break; end
                end
                if (!got) begin e_err = 1; continue; end
                e_cs_n = 0;
                repeat (H) @(posedge clk);
                e_sclk = 0;
                for (int f = 1; f <= (m_single ? 2*DW+PW : DW); f++) begin
                    if (f > 1) begin repeat (H) @(posedge clk); e_sclk = 0; end
                    repeat (H) @(posedge clk);
                    e_sclk = 1;
                end
                e_cs_n = 1; e_valid = 1;
                e_res_a = m_wa; e_res_b = m_wb;
                res_tag = m_single ? "R6 result" : "R5 result";
            end
        end
    end

    // ---------- per-cycle comparison ----------
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 cnv_n", cnv_n_o, e_cnv_n);
            chk("R2 cs_n", cs_n_o, e_cs_n);
            chk("R3 R4 sclk", sclk_o, e_sclk);
            chk("R7 valid", res_valid_o, e_valid);
            chk("R8 err", err_o, e_err);
            chk({res_tag, " A"}, res_a_o, e_res_a);
            chk({res_tag, " B"}, res_b_o, e_res_b);
        end
    end

    task automatic run_conv(input logic sp, input logic [DW-1:0] wa, input logic [DW-1:0] wb,
                            input int d_hi, input int d_lo, input logic poke);
        cur_wa = wa; cur_wb = wb;
        if (sp) begin stream_a = {wa, 2'b00, wb}; stream_b = {~wb, 2'b11, ~wa}; end
        else    begin stream_a = {wa, 14'h2A5A};  stream_b = {wb, 14'h15A5}; end
        @(negedge clk); single_pin_i = sp; start_i = 1;
        @(negedge clk); start_i = 0;
        repeat (d_hi) @(negedge clk);
        busy_i = 1;
        if (poke) begin start_i = 1; single_pin_i = ~sp; end   // R1, R4: ignored
        @(negedge clk); start_i = 0;
        repeat (d_lo) @(negedge clk);
        busy_i = 0;
        repeat (2*H*(2*DW+PW) + H + 10) @(negedge clk);
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // ---------- stimulus ----------
    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset cnv_n", cnv_n_o, 1'b1);
        chk("R9 reset cs_n", cs_n_o, 1'b1);
        chk("R9 reset sclk", sclk_o, 1'b1);
        chk("R9 reset valid", res_valid_o, 1'b0);
        chk("R9 reset err", err_o, 1'b0);
        chk("R9 reset res A", res_a_o, '0);
        chk("R9 reset res B", res_b_o, '0);
        rst = 0;
        repeat (2) @(negedge clk);

        run_conv(1'b0, 12'hA5C, 12'h3E1, 3, 10, 1'b1);  // R5 dual
        run_conv(1'b1, 12'h801, 12'h7FE, 2, 8,  1'b1);  // R6 single
        run_conv(1'b0, 12'hFFF, 12'h000, 1, 5,  1'b0);  // R5 extremes
        run_conv(1'b1, 12'h000, 12'hFFF, 4, 12, 1'b0);  // R6 fill bits dropped
        run_conv(1'b1, 12'h5A3, 12'hC3C, 5, 3,  1'b1);  // R6 pattern
        run_conv(1'b0, 12'h123, 12'h456, 70, 4, 1'b0);  // R8 busy never rises
        run_conv(1'b1, 12'h321, 12'h654, 2, 70, 1'b0);  // R8 busy never falls
        run_conv(1'b0, 12'h9C6, 12'h6C9, 2, 6,  1'b0);  // recovery after timeout

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule